// File: doc/BRIEF.md
# Routing Interrupt Controller

This block gathers a set of interrupt sources and steers each one onto one of a small number of interrupt lines toward a processor. Every source has its own configuration word. That word holds an enable, the number of the output line it drives, and a thread-identifier field. The thread identifier is kept for software but plays no part in routing. A single pending vector records which sources have fired. Software reads the vector from one address window and changes it through two more windows: a write-one-to-set window and a write-one-to-clear window.

The lower sources come from hardware as level inputs. A high level latches the pending bit, and the bit stays set until software clears it. The upper sources have no hardware input. Only a write to the set window raises them, so one processor can use them to signal another. An output line stays high while at least one source meets all three conditions: it is pending, it is enabled, and it is routed to that line.

The register interface is a plain single-cycle write port with a combinational read. The byte address splits into a 2-bit region field at the top and a source index at bit 3 and above, so configuration words sit 8 bytes apart. Address bits [2:0] are ignored. Regions are 0 = configuration, 1 = pending read, 2 = pending set, 3 = pending clear. With the defaults the address is 10 bits wide and the region field is bits [9:8].

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every pending bit, every configuration word and every output line is zero.
- R2: A write to configuration word i (region 0, byte offset i*8) stores bit 31 as the enable, bits [30:8] as the thread identifier and bits [3:0] as the route. A read of that word returns those fields in the same positions, and all other bits read as zero.
- R3: A read of region 1 returns the pending vector, with bit i for source i. Bits at and above the source count read as zero.
- R4: A write to region 2 sets pending bit i for every 1 in bit i of the data. Bits written as 0 leave their pending bits unchanged.
- R5: A write to region 3 clears pending bit i for every 1 in bit i of the data. Bits written as 0 leave their pending bits unchanged.
- R6: A high level on hardware input i (sources 0 to 15) sets pending bit i at the next clock edge. The bit stays set after the level drops, until it is cleared through region 3.
- R7: Sources 16 to 31 have no hardware input. A write to region 2 raises them and a write to region 3 lowers them.
- R8: Output k is high exactly when some source is pending, enabled and has route field equal to k.
- R9: A disabled source drives no output. A route value of 5 or more drives no output.
- R10: When a set and a clear reach the same pending bit in one cycle, the bit ends up set. This covers a hardware level that is high during a clear write.
- R11: A write to region 1 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_src | input | 16 | Level inputs for hardware sources 0..15 |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | 10 | Byte address: region [9:8], source index [7:3] |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for bus_addr, combinational |
| irq_out | output | 5 | Interrupt lines toward the processor |

## Verification
The bench builds the controller with its default values: 32 sources, 5 output lines and 16 hardware inputs. With these values the software-only upper half is reachable, and a route value of 7 tests the case of a route field wider than the line count. Source 31 tests the all-ones configuration readback at the top of the address space. One hardware line is held high during a clear write to test the case where set beats clear.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  typedef enum logic [1:0] {
    RGN_CFG  = 2'd0,
    RGN_PEND = 2'd1,
    RGN_SET  = 2'd2,
    RGN_CLR  = 2'd3
  } region_e;

  localparam int unsigned WORD_W    = 64;
  localparam int unsigned ROUTE_W   = 4;
  localparam int unsigned ROUTE_LSB = 0;
  localparam int unsigned TID_W     = 23;
  localparam int unsigned TID_LSB   = 8;
  localparam int unsigned EN_BIT    = 31;
  localparam int unsigned STRIDE_SH = 3;

endpackage

// File: rtl/irq_cfg_bank.sv
module irq_cfg_bank
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [IDX_W-1:0]                  idx,
  input  logic [WORD_W-1:0]                 wdata,
  output logic [NUM_SRC-1:0]                en_vec,
  output logic [NUM_SRC-1:0][ROUTE_W-1:0]   route_vec,
  output logic [WORD_W-1:0]                 rd_word
);

  logic [NUM_SRC-1:0][TID_W-1:0] tid_vec;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_vec[s]    <= 1'b0;
        route_vec[s] <= '0;
        tid_vec[s]   <= '0;
      end else if (we && idx == IDX_W'(s)) begin
        en_vec[s]    <= wdata[EN_BIT];
        route_vec[s] <= wdata[ROUTE_LSB +: ROUTE_W];
        tid_vec[s]   <= wdata[TID_LSB +: TID_W];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    rd_word[EN_BIT]               = en_vec[idx];
    rd_word[TID_LSB +: TID_W]     = tid_vec[idx];
    rd_word[ROUTE_LSB +: ROUTE_W] = route_vec[idx];
  end

  AST_CFG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (en_vec[$past(idx)] == $past(wdata[EN_BIT]))
        && (route_vec[$past(idx)] == $past(wdata[ROUTE_LSB +: ROUTE_W]))); // R2

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(en_vec) && $stable(route_vec))); // R11

endmodule

// File: rtl/irq_pend_vec.sv
module irq_pend_vec #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned NUM_HW  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_HW-1:0]  hw_lvl,
  input  logic [NUM_SRC-1:0] set_mask,
  input  logic [NUM_SRC-1:0] clr_mask,
  output logic [NUM_SRC-1:0] pend
);

  localparam logic [NUM_SRC-1:0] HW_MASK = NUM_SRC'((64'd1 << NUM_HW) - 64'd1);

  logic [NUM_SRC-1:0] raise;

  assign raise = set_mask | NUM_SRC'(hw_lvl);

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_mask) | raise;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(raise)) == $past(raise))); // R10

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(clr_mask & ~raise)) == '0)); // R5

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pend ^ $past(pend)) & ~$past(raise | clr_mask)) == '0)); // R6

  AST_SOFT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(set_mask) & ~HW_MASK) == '0)); // R7

endmodule

// File: rtl/irq_route_or.sv
module irq_route_or
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned NUM_OUT = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0]              pend,
  input  logic [NUM_SRC-1:0]              en_vec,
  input  logic [NUM_SRC-1:0][ROUTE_W-1:0] route_vec,
  output logic [NUM_OUT-1:0]              irq_out
);

  logic [NUM_SRC-1:0] live;

  assign live = pend & en_vec;

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_line
    logic [NUM_SRC-1:0] hit;
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_cmp
      assign hit[s] = live[s] && (route_vec[s] == ROUTE_W'(k));
    end
    assign irq_out[k] = |hit;
  end

  AST_NO_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
    (live == '0) |-> (irq_out == '0)); // R9

  AST_LINE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_out) <= $countones(live)); // R8

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned NUM_OUT = 5,
  parameter int unsigned NUM_HW  = 16,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC),
  localparam int unsigned ADDR_W = IDX_W + STRIDE_SH + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_HW-1:0]  irq_src,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  output logic [NUM_OUT-1:0] irq_out
);

  region_e                          region;
  logic [IDX_W-1:0]                 idx;
  logic                             cfg_we;
  logic [NUM_SRC-1:0]               set_mask;
  logic [NUM_SRC-1:0]               clr_mask;
  logic [NUM_SRC-1:0]               pend;
  logic [NUM_SRC-1:0]               en_vec;
  logic [NUM_SRC-1:0][ROUTE_W-1:0]  route_vec;
  logic [WORD_W-1:0]                cfg_word;

  assign region   = region_e'(bus_addr[ADDR_W-1 -: 2]);
  assign idx      = bus_addr[STRIDE_SH +: IDX_W];
  assign cfg_we   = bus_wr && (region == RGN_CFG);
  assign set_mask = (bus_wr && region == RGN_SET) ? bus_wdata[NUM_SRC-1:0] : '0;
  assign clr_mask = (bus_wr && region == RGN_CLR) ? bus_wdata[NUM_SRC-1:0] : '0;

  irq_cfg_bank #(.NUM_SRC(NUM_SRC)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(idx), .wdata(bus_wdata),
    .en_vec(en_vec), .route_vec(route_vec), .rd_word(cfg_word)
  );

  irq_pend_vec #(.NUM_SRC(NUM_SRC), .NUM_HW(NUM_HW)) u_pend (
    .clk(clk), .rst_n(rst_n), .hw_lvl(irq_src),
    .set_mask(set_mask), .clr_mask(clr_mask), .pend(pend)
  );

  irq_route_or #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT)) u_route (
    .clk(clk), .rst_n(rst_n), .pend(pend), .en_vec(en_vec),
    .route_vec(route_vec), .irq_out(irq_out)
  );

  always_comb begin
    unique case (region)
      RGN_CFG:  bus_rdata = cfg_word;
      RGN_PEND: bus_rdata = WORD_W'(pend);
      default:  bus_rdata = '0;
    endcase
  end

  AST_RESET_CLEAN: assert property (@(posedge clk)
    !rst_n |=> (pend == '0 && en_vec == '0)); // R1

  AST_PEND_WR_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && region == RGN_PEND) |=> $stable(en_vec)); // R11

endmodule

// File: tb/irq_route_ctrl_tb.sv
module irq_route_ctrl_tb_top;

  localparam int NV = 11;
  localparam logic [9:0] A_PEND = 10'h100;
  localparam logic [9:0] A_SET  = 10'h200;
  localparam logic [9:0] A_CLR  = 10'h300;

  // {addr, wdata, hw levels, expected pending, expected lines}
  localparam logic [94:0] VEC [NV] = '{
    {10'h018, 32'h8000_0002, 16'h0000, 32'h0000_0000, 5'h00},
    {A_PEND,  32'hFFFF_FFFF, 16'h0008, 32'h0000_0008, 5'h04},
    {A_PEND,  32'h0000_0000, 16'h0000, 32'h0000_0008, 5'h04},
    {A_CLR,   32'h0000_0008, 16'h0000, 32'h0000_0000, 5'h00},
    {10'h0A0, 32'h8000_0004, 16'h0000, 32'h0000_0000, 5'h00},
    {A_SET,   32'h0010_0020, 16'h0000, 32'h0010_0020, 5'h10},
    {10'h028, 32'h8000_0007, 16'h0000, 32'h0010_0020, 5'h10},
    {10'h028, 32'h8000_0000, 16'h0000, 32'h0010_0020, 5'h11},
    {A_CLR,   32'h0010_0000, 16'h0000, 32'h0000_0020, 5'h01},
    {A_SET,   32'h0000_0000, 16'h0000, 32'h0000_0020, 5'h01},
    {10'h028, 32'h0000_0000, 16'h0000, 32'h0000_0020, 5'h00}
  };
  localparam string VTAG [NV] = '{"R2", "R11", "R6", "R5", "R7", "R4",
                                  "R9", "R8", "R5", "R4", "R9"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_src = '0;
  logic        bus_wr = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic [4:0]  irq_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_route_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one write with the given hw levels, then park the bus on the pending window
  task automatic step(input logic [9:0] a, input logic [63:0] d, input logic [15:0] hw);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; irq_src = hw;
    @(posedge clk);
    #1;
    bus_wr = 1'b0; bus_addr = A_PEND;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    bus_addr = A_PEND; #1;
    check("R1 pending", bus_rdata, 64'h0);
    check("R1 lines", 64'(irq_out), 64'h0);
    bus_addr = 10'h0F8; #1;
    check("R1 config", bus_rdata, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      step(VEC[v][94:85], 64'(VEC[v][84:53]), VEC[v][52:37]);
      check({VTAG[v], " pending"}, bus_rdata, 64'(VEC[v][36:5]));
      check({VTAG[v], " lines"}, 64'(irq_out), 64'(VEC[v][4:0]));
    end

    // R2: full-width write to the last word, only the fields read back
    step(10'h0F8, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0);
    bus_addr = 10'h0F8; #1;
    check("R2 readback", bus_rdata, 64'h0000_0000_FFFF_FF0F);
    // route 15 on enabled source 31 drives nothing (R9)
    step(A_SET, 64'h8000_0000, 16'h0);
    check("R3 upper bit", bus_rdata, 64'h8000_0020);
    check("R9 route15", 64'(irq_out), 64'h0);

    // R10: hardware level held high during a clear keeps the bit
    step(A_CLR, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0002);
    check("R10 hw beats clear", bus_rdata, 64'h0000_0002);
    step(A_CLR, 64'h0000_0002, 16'h0000);
    check("R5 clear after drop", bus_rdata, 64'h0);

    // R7: pulsing every hardware line leaves the upper half untouched
    step(A_PEND, 64'h0, 16'hFFFF);
    check("R7 upper untouched", bus_rdata, 64'h0000_FFFF);

    // R1: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0; irq_src = '0;
    @(posedge clk); #1;
    check("R1 re-reset pending", bus_rdata, 64'h0);
    bus_addr = 10'h018; #1;
    check("R1 re-reset config", bus_rdata, 64'h0);
    rst_n = 1'b1;

    finish_run();
  end

endmodule